// File: doc/BRIEF.md
# Memory Request Coalescing Checker

This block looks at the memory requests of a 16-lane group for one load or store instruction and decides how to send them to memory. Each lane gives an active flag and a byte address, and one element size applies to the whole group. If the active lanes together form one aligned run of elements, the block sends a single burst request. That request carries the start address of the run and its length in bytes. If they do not, the block sends one request per active lane, one lane at a time, in ascending lane order.

The instruction is taken through a valid/ready pair on the input side. Requests leave through a valid/ready pair on the output side. A one-cycle done pulse follows the last request of an instruction. The block takes the next instruction only after every request of the current one has been accepted.

To form the burst, the block takes the lowest-numbered active lane. It subtracts that lane's index times the element size from the lane's address, and the result is the region base. The run is 16 elements long.

Top module: `mem_coalesce_unit`

## Requirements
- R1: Only element sizes of 4, 8 and 16 bytes can form a burst. With any other size (for example 12), each active lane gets its own request.
- R2: The group forms a burst in one case only. The region base must be a multiple of 16 times the element size, and every active lane k must address base + k*size. The single request then has req_burst=1, req_addr=base and req_len=16*size.
- R3: If the region base is not a multiple of 16 times the element size, the group falls back to one request per active lane.
- R4: If any active lane addresses an element slot other than its own (for example two lanes swapped), the group falls back to one request per active lane.
- R5: Inactive lanes do not block a burst. The region base comes from the lowest-numbered active lane, even when lane 0 is inactive.
- R6: In fallback, one request goes out for each active lane, in ascending lane order, with req_burst=0, req_addr equal to that lane's address and req_len equal to the element size. Each request is consumed by one accepted handshake.
- R7: While req_valid is high and req_ready is low, req_valid stays high and req_addr, req_len and req_burst stay unchanged.
- R8: done is high for exactly one cycle: the cycle after the final request handshake of an instruction. At that point req_valid is low and in_ready is high.
- R9: An instruction with no active lane issues no request. done is high in the cycle after the instruction is accepted.
- R10: in_ready is low while any request of the current instruction is still outstanding.
- R11: After reset, in_ready is 1, and req_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can accept an instruction |
| in_active | input | LANES | Per-lane active flags, bit k for lane k |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane k at bits [k*ADDR_W +: ADDR_W] |
| in_esize | input | SIZE_W | Element size in bytes, common to all lanes |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_burst | output | 1 | 1 for a burst request, 0 for a single-lane request |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | SIZE_W+log2(LANES) | Request length in bytes |
| done | output | 1 | One-cycle pulse after the last request |

## Verification
The checker watches the handshake rules on every cycle. A stalled request must hold its fields, in_ready must stay low while a request is pending, and done must be a single-cycle pulse that comes back with in_ready. Every burst address must also be aligned to its own length. Whether the coalescing decision is right for a given lane pattern can only be shown by the bench's scenarios. These cover unsupported sizes, misaligned bases, swapped lanes, holes in the active mask and empty groups, and each one is compared, request by request, with an independently computed list.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } coal_state_t;
endpackage

// File: rtl/coal_first.sv
// Priority encoder: lowest set bit of a mask.
module coal_first #(
  parameter int LANES = 16,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] mask,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (mask[k]) begin
        idx   = IDX_W'(k);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_judge.sv
// Decides whether the active lanes form one aligned contiguous run.
module coal_judge #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]        active,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [SIZE_W-1:0]       esize,
  output logic                    any_active,
  output logic                    burst_ok,
  output logic [ADDR_W-1:0]       base
);
  logic [IDX_W-1:0]  first_idx;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] region_mask;
  logic [LANES-1:0]  slot_ok;
  logic              size_ok;

  coal_first #(.LANES(LANES)) u_first (
    .mask (active),
    .idx  (first_idx),
    .found(any_active)
  );

  assign first_addr  = addr_flat[first_idx*ADDR_W +: ADDR_W];
  assign base        = first_addr - ADDR_W'(first_idx) * ADDR_W'(esize);
  assign region_mask = ADDR_W'(esize) * ADDR_W'(LANES) - ADDR_W'(1);
  assign size_ok     = (esize == SIZE_W'(4)) || (esize == SIZE_W'(8)) ||
                       (esize == SIZE_W'(16));

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    logic [ADDR_W-1:0] want;
    assign want       = base + ADDR_W'(k) * ADDR_W'(esize);
    assign slot_ok[k] = !active[k] || (addr_flat[k*ADDR_W +: ADDR_W] == want);
  end

  assign burst_ok = any_active && size_ok && ((base & region_mask) == '0) &&
                    (&slot_ok);
endmodule

// File: rtl/mem_coalesce_unit.sv
module mem_coalesce_unit #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LEN_W = SIZE_W + IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        in_active,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0]       in_esize,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic                    req_burst,
  output logic [ADDR_W-1:0]       req_addr,
  output logic [LEN_W-1:0]        req_len,
  output logic                    done
);
  import coal_pkg::*;

  coal_state_t       st_q;
  logic [LANES-1:0]  pend_q;
  logic [ADDR_W-1:0] addr_q [LANES];
  logic [SIZE_W-1:0] esize_q;
  logic              burst_q;
  logic [ADDR_W-1:0] base_q;
  logic              done_q;

  logic              j_any, j_burst;
  logic [ADDR_W-1:0] j_base;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_found;
  logic [LANES-1:0]  cur_bit;
  logic              accept, fire, last_lane;

  coal_judge #(.LANES(LANES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_judge (
    .active    (in_active),
    .addr_flat (in_addr),
    .esize     (in_esize),
    .any_active(j_any),
    .burst_ok  (j_burst),
    .base      (j_base)
  );

  coal_first #(.LANES(LANES)) u_next (
    .mask (pend_q),
    .idx  (cur_idx),
    .found(cur_found)
  );

  assign cur_bit   = cur_found ? (LANES'(1) << cur_idx) : '0;
  assign last_lane = ((pend_q & ~cur_bit) == '0);
  assign in_ready  = (st_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign req_valid = (st_q == ST_SEND);
  assign fire      = req_valid && req_ready;
  assign req_burst = burst_q;
  assign req_addr  = burst_q ? base_q : addr_q[cur_idx];
  assign req_len   = burst_q ? LEN_W'(esize_q) * LEN_W'(LANES) : LEN_W'(esize_q);
  assign done      = done_q;

  // Lane address store: plain write-enable array without reset.
  for (genvar k = 0; k < LANES; k++) begin : g_store
    always_ff @(posedge clk) begin
      if (accept) addr_q[k] <= in_addr[k*ADDR_W +: ADDR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      esize_q <= '0;
      burst_q <= 1'b0;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend_q  <= in_active;
        esize_q <= in_esize;
        burst_q <= j_burst;
        base_q  <= j_base;
        if (j_any) st_q <= ST_SEND;
        else done_q <= 1'b1;
      end else if (fire) begin
        if (burst_q || last_lane) begin
          st_q   <= ST_IDLE;
          pend_q <= '0;
          done_q <= 1'b1;
        end else begin
          pend_q <= pend_q & ~cur_bit;
        end
      end
    end
  end
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_burst,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              done
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_len) && $stable(req_burst)));
  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !in_ready);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (in_ready && !req_valid));
  // R2
  burst_align_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_burst) |->
      ((req_addr & (ADDR_W'(req_len) - ADDR_W'(1))) == '0));
  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!req_valid && !done && in_ready));
endmodule

bind mem_coalesce_unit coal_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_burst(req_burst),
  .req_addr (req_addr),
  .req_len  (req_len),
  .done     (done)
);

// File: tb/sim_mem_coalesce_unit.sv
module sim_mem_coalesce_unit;
  localparam int L  = 16;
  localparam int AW = 32;
  localparam int SW = 5;
  localparam int LW = 9;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic in_ready;
  logic [L-1:0] in_active = '0;
  logic [L*AW-1:0] in_addr = '0;
  logic [SW-1:0] in_esize = '0;
  logic req_valid;
  logic req_ready = 0;
  logic req_burst;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic done;

  int total = 0;
  int bad = 0;

  logic [AW-1:0] st_addr [L];
  logic [AW-1:0] ea [L];
  logic [LW-1:0] el [L];
  logic          eb [L];
  int            en;

  always #10 clk = ~clk;

  mem_coalesce_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_addr(in_addr), .in_esize(in_esize),
    .req_valid(req_valid), .req_ready(req_ready), .req_burst(req_burst),
    .req_addr(req_addr), .req_len(req_len), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected request list, built straight from the requirements.
  task automatic build_exp(input logic [L-1:0] act, input int es);
    int f;
    logic [AW-1:0] base;
    bit ok;
    f = -1;
    for (int k = L - 1; k >= 0; k--) if (act[k]) f = k;
    en = 0;
    if (f < 0) return;
    base = st_addr[f] - AW'(f * es);
    ok = (es == 4 || es == 8 || es == 16) && ((base % AW'(16 * es)) == 0);
    for (int k = 0; k < L; k++)
      if (act[k] && st_addr[k] != base + AW'(k * es)) ok = 0;
    if (ok) begin
      ea[0] = base; el[0] = LW'(16 * es); eb[0] = 1; en = 1;
    end else begin
      for (int k = 0; k < L; k++) if (act[k]) begin
        ea[en] = st_addr[k]; el[en] = LW'(es); eb[en] = 0; en++;
      end
    end
  endtask

  task automatic run_instr(input logic [L-1:0] act, input int es,
                           input string tag, input int stall_pct);
    int idx;
    build_exp(act, es);
    @(negedge clk);
    chk(in_ready == 1, "R10", "in_ready when idle", in_ready, 1);
    in_valid = 1; in_active = act; in_esize = SW'(es);
    for (int k = 0; k < L; k++) in_addr[k*AW +: AW] = st_addr[k];
    @(negedge clk);
    in_valid = 0;
    if (en == 0) begin
      chk(done == 1, "R9", "done after empty group", done, 1);
      chk(req_valid == 0, "R9", "no request for empty group", req_valid, 0);
      return;
    end
    idx = 0;
    while (idx < en) begin
      bit rr;
      chk(req_valid == 1, tag, "request pending", req_valid, 1);
      chk(in_ready == 0, "R10", "in_ready while busy", in_ready, 0);
      chk(done == 0, "R8", "done early", done, 0);
      rr = (($urandom % 100) >= stall_pct);
      req_ready = rr;
      if (rr && req_valid) begin
        chk(req_burst == eb[idx], tag, "burst flag", req_burst, eb[idx]);
        chk(req_addr == ea[idx], tag, "address", req_addr, ea[idx]);
        chk(req_len == el[idx], tag, "length", req_len, el[idx]);
        idx++;
      end
      @(negedge clk);
      if (!req_valid && idx < en) break;
    end
    req_ready = 0;
    chk(done == 1, "R8", "done after last request", done, 1);
    chk(req_valid == 0, "R8", "valid after last request", req_valid, 0);
    chk(in_ready == 1, "R8", "ready after last request", in_ready, 1);
    @(negedge clk);
    chk(done == 0, "R8", "done width", done, 0);
  endtask

  task automatic fill_run(input logic [AW-1:0] base, input int es);
    for (int k = 0; k < L; k++) st_addr[k] = base + AW'(k * es);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4521));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(in_ready == 1 && req_valid == 0 && done == 0, "R11", "reset state",
        {in_ready, req_valid, done}, 3'b100);

    // R2: full aligned runs, each size
    fill_run(32'h0000_1000, 4);  run_instr('1, 4, "R2", 0);
    fill_run(32'h0000_2100, 8);  run_instr('1, 8, "R2", 30);
    fill_run(32'h0000_3300, 16); run_instr('1, 16, "R2", 50);
    // R1: unsupported size
    fill_run(32'h0000_0C00, 12); run_instr(16'h00FF, 12, "R1", 0);
    // R3: misaligned base
    fill_run(32'h0000_1040, 8);  run_instr('1, 8, "R3", 20);
    // R4: swapped lanes
    fill_run(32'h0000_4000, 4);
    st_addr[2] = 32'h0000_4000 + 12; st_addr[3] = 32'h0000_4000 + 8;
    run_instr('1, 4, "R4", 20);
    // R5: holes, lane 0 inactive
    fill_run(32'h0000_5000, 16); st_addr[0] = 32'hDEAD_BEE0;
    run_instr(16'b1010_0110_1100_0010, 16, "R5", 40);
    // R6: single lane and random addresses
    for (int k = 0; k < L; k++) st_addr[k] = $urandom;
    run_instr(16'h8001, 4, "R6", 60);
    // R9: nothing active
    run_instr('0, 8, "R9", 0);

    for (int n = 0; n < 300; n++) begin
      int es, mode;
      logic [L-1:0] act;
      logic [AW-1:0] b;
      int sz [4] = '{4, 8, 12, 16};
      es = sz[$urandom % 4];
      act = L'($urandom);
      if (($urandom % 8) == 0) act = '0;
      mode = $urandom % 4;
      b = ($urandom & 32'h00FF_FF00) & ~(AW'(16 * es) - 1);
      fill_run(b, es);
      if (mode == 1) for (int k = 0; k < L; k++) st_addr[k] = st_addr[k] + AW'(es);
      if (mode == 2) begin
        logic [AW-1:0] t;
        t = st_addr[5]; st_addr[5] = st_addr[9]; st_addr[9] = t;
      end
      if (mode == 3) for (int k = 0; k < L; k++) st_addr[k] = $urandom;
      run_instr(act, es, (mode == 0) ? "R2" : "R6", $urandom % 60);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule